// File: doc/BRIEF.md
# Streaming 2x2 Matrix-Vector Multiplier

The block keeps one signed 2x2 weight matrix and multiplies it by a stream of signed 2-element vectors. The matrix is written in a single cycle from a packed 32-bit word. Input elements arrive one per cycle and are paired in arrival order: the first element of a pair is x0 and the second is x1. When x1 arrives, both rows are evaluated at once with exact signed arithmetic. The two 17-bit results then leave the block one after the other.

Two state machines carry the control. The pairing machine has two states, `PH_EXPECT_X0` and `PH_EXPECT_X1`. An accepted element moves it from `PH_EXPECT_X0` to `PH_EXPECT_X1`, where it captures x0. The next accepted element moves it back to `PH_EXPECT_X0` and fires a pair. The emitter machine has three states: `EM_IDLE`, `EM_ROW0` and `EM_ROW1`. A pair fired while in `EM_IDLE` or `EM_ROW1` moves it to `EM_ROW0`. `EM_ROW0` always moves on to `EM_ROW1`. `EM_ROW1` drops to `EM_IDLE` when no new pair is fired. Reset sends both machines to their first state. Because `EM_ROW1` can go straight to `EM_ROW0`, vectors can follow each other with no gap, and new elements are taken while older results are still being driven.

Top module: `mv2_matvec`

## Requirements
- R1: On a rising edge with reset low and the load input high, the block stores the weight word. The fields are a00 = bits 7:0, a01 = bits 15:8, a10 = bits 23:16 and a11 = bits 31:24, each a signed 8-bit value.
- R2: A load cycle accepts no element, even when the input valid is high. The next accepted element after a load is taken as x0.
- R3: An element is accepted on a rising edge with reset low, load low and valid high. Accepted elements alternate between x0 and x1.
- R4: The results are r0 = a00*x0 + a01*x1 and r1 = a10*x0 + a11*x1. They are computed exactly in signed arithmetic and given as signed 17-bit values. For example, -128*-128 in both terms gives +32768.
- R5: If x1 is accepted on the edge that ends cycle N, then during cycle N+1 the valid output is 1 and the data output carries r0.
- R6: During cycle N+2, the valid output is 1 and the data output carries r1.
- R7: Vectors may be sent back to back with no gap. Elements are accepted while the results of earlier vectors are being driven.
- R8: In any cycle with no scheduled result, both the valid output and the data output are 0.
- R9: A synchronous active-high reset does four things. It zeroes the weights, drops a half-received vector, cancels pending results, and drives both outputs to 0.
- R10: The weights stay in effect for every later vector until the next load. After reset they read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| weight_load | input | 1 | Store weight_data on this edge |
| weight_data | input | 32 | Packed signed weights a00..a11 |
| in_valid | input | 1 | in_data holds an element |
| in_data | input | 8 | Signed input element |
| out_valid | output | 1 | out_data holds a result |
| out_data | output | 17 | Signed result, r0 then r1 |

## Verification
The hardest case to reach from the ports is a fresh pair arriving in the same cycle that r1 of the previous vector is driven. At that point the emitter goes from `EM_ROW1` straight to `EM_ROW0`, and the held r1 must not be overwritten before it is driven. The bench reaches this case with long runs of gap-free random vectors. It also asserts reset right after an x0 and right after the first result, which checks that half-received vectors and pending r1 values are dropped.

// File: rtl/mv2_pkg.sv
package mv2_pkg;

    typedef enum logic {
        PH_EXPECT_X0 = 1'b0,
        PH_EXPECT_X1 = 1'b1
    } pair_state_e;

    typedef enum logic [1:0] {
        EM_IDLE = 2'd0,
        EM_ROW0 = 2'd1,
        EM_ROW1 = 2'd2
    } emit_state_e;

endpackage

// File: rtl/mv2_weight_bank.sv
module mv2_weight_bank #(
    parameter int ELEM_W = 8,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [LANES*ELEM_W-1:0]   load_word,
    output logic [LANES*ELEM_W-1:0]   w_flat
);
    logic [LANES*ELEM_W-1:0] w_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q <= '0;
        end else if (load) begin
            w_q <= load_word;
        end
    end

    assign w_flat = w_q;

    // Weights hold their value between loads (R10)
    assert_weights_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(w_flat));

    // Reset clears the bank (R9)
    assert_weights_cleared_R9: assert property (@(posedge clk)
        rst |=> (w_flat == '0));

endmodule

// File: rtl/mv2_pair_fsm.sv
module mv2_pair_fsm
    import mv2_pkg::*;
#(
    parameter int ELEM_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     in_valid,
    input  logic signed [ELEM_W-1:0] in_data,
    output logic                     pair_fire,
    output logic signed [ELEM_W-1:0] x0_held
);
    pair_state_e             state_q, state_d;
    logic signed [ELEM_W-1:0] x0_q;
    logic                     take;

    assign take = !rst && !load && in_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_EXPECT_X0: if (take) state_d = PH_EXPECT_X1;
            PH_EXPECT_X1: if (take) state_d = PH_EXPECT_X0;
            default:      state_d = PH_EXPECT_X0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_EXPECT_X0;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x0_q <= '0;
        end else if (take && state_q == PH_EXPECT_X0) begin
            x0_q <= in_data;
        end
    end

    assign pair_fire = take && (state_q == PH_EXPECT_X1);
    assign x0_held   = x0_q;

    // Pairs cannot fire on two consecutive edges (R3)
    assert_pair_alternate_R3: assert property (@(posedge clk) disable iff (rst)
        pair_fire |=> !pair_fire);

    // A load cycle never completes a pair (R2)
    assert_load_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        load |-> !pair_fire);

endmodule

// File: rtl/mv2_dot_row.sv
module mv2_dot_row #(
    parameter int ELEM_W = 8,
    parameter int OUT_W  = 2*ELEM_W + 1
) (
    input  logic signed [ELEM_W-1:0] w_a,
    input  logic signed [ELEM_W-1:0] w_b,
    input  logic signed [ELEM_W-1:0] x_a,
    input  logic signed [ELEM_W-1:0] x_b,
    output logic signed [OUT_W-1:0]  dot
);
    localparam int PROD_W = 2*ELEM_W;

    logic signed [PROD_W-1:0] p_a, p_b;
    logic signed [OUT_W-1:0]  e_a, e_b;

    always_comb begin
        p_a = w_a * x_a;
        p_b = w_b * x_b;
        e_a = OUT_W'(p_a);
        e_b = OUT_W'(p_b);
        dot = e_a + e_b;
    end

endmodule

// File: rtl/mv2_emit_fsm.sv
module mv2_emit_fsm
    import mv2_pkg::*;
#(
    parameter int OUT_W = 17
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire,
    input  logic signed [OUT_W-1:0] row0,
    input  logic signed [OUT_W-1:0] row1,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_data
);
    emit_state_e       state_q, state_d;
    logic [OUT_W-1:0]  hold_q;
    logic [OUT_W-1:0]  data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EM_IDLE: state_d = fire ? EM_ROW0 : EM_IDLE;
            EM_ROW0: state_d = EM_ROW1;
            EM_ROW1: state_d = fire ? EM_ROW0 : EM_IDLE;
            default: state_d = EM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            hold_q <= '0;
        end else if (fire) begin
            data_q <= row0;
            hold_q <= row1;
        end else if (state_q == EM_ROW0) begin
            data_q <= hold_q;
        end else begin
            data_q <= '0;
        end
    end

    assign out_valid = (state_q != EM_IDLE);
    assign out_data  = data_q;

    // Row 0 appears on the cycle after the pair (R5)
    assert_row0_slot_R5: assert property (@(posedge clk) disable iff (rst)
        fire |=> out_valid);

    // Row 1 follows one cycle later (R6)
    assert_row1_slot_R6: assert property (@(posedge clk) disable iff (rst)
        fire |-> ##2 out_valid);

    // No scheduled result means zero data (R8)
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));

    // Reset silences the outputs (R9)
    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

endmodule

// File: rtl/mv2_matvec.sv
module mv2_matvec #(
    parameter int  ELEM_W = 8,
    localparam int DIM    = 2,
    localparam int OUT_W  = 2*ELEM_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    weight_load,
    input  logic [DIM*DIM*ELEM_W-1:0] weight_data,
    input  logic                    in_valid,
    input  logic [ELEM_W-1:0]       in_data,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_data
);
    logic [DIM*DIM*ELEM_W-1:0] w_flat;
    logic                      pair_fire;
    logic signed [ELEM_W-1:0]  x0_held;
    logic signed [ELEM_W-1:0]  x1_now;
    logic signed [OUT_W-1:0]   row_res [DIM];

    assign x1_now = in_data;

    mv2_weight_bank #(.ELEM_W(ELEM_W), .LANES(DIM*DIM)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .load      (weight_load),
        .load_word (weight_data),
        .w_flat    (w_flat)
    );

    mv2_pair_fsm #(.ELEM_W(ELEM_W)) u_pair (
        .clk       (clk),
        .rst       (rst),
        .load      (weight_load),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .pair_fire (pair_fire),
        .x0_held   (x0_held)
    );

    for (genvar r = 0; r < DIM; r++) begin : g_row
        mv2_dot_row #(.ELEM_W(ELEM_W), .OUT_W(OUT_W)) u_row (
            .w_a (w_flat[(r*DIM+0)*ELEM_W +: ELEM_W]),
            .w_b (w_flat[(r*DIM+1)*ELEM_W +: ELEM_W]),
            .x_a (x0_held),
            .x_b (x1_now),
            .dot (row_res[r])
        );
    end

    mv2_emit_fsm #(.OUT_W(OUT_W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .fire      (pair_fire),
        .row0      (row_res[0]),
        .row1      (row_res[1]),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // A load cycle schedules no result for the next cycle (R2)
    assert_load_no_result_R2: assert property (@(posedge clk) disable iff (rst)
        (weight_load && !out_valid) |=> !out_valid);

endmodule

// File: tb/mv2_matvec_tb.sv
`timescale 1ns/1ps
module mv2_matvec_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        weight_load;
    logic [31:0] weight_data;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        out_valid;
    logic [16:0] out_data;

    always #2.5 clk = ~clk;

    mv2_matvec u_dut (
        .clk(clk), .rst(rst), .weight_load(weight_load), .weight_data(weight_data),
        .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    primed = 0;
    bit    done   = 0;
    string tag    = "R8";

    // behavioural reference
    int    mw [4];
    bit    mph;
    int    mx0;
    bit    cur_v, nxt_v;
    int    cur_d, nxt_d;
    string cur_t, nxt_t;

    always @(posedge clk) begin
        primed = 1;
        if (rst) begin
            for (int k = 0; k < 4; k++) mw[k] = 0;
            mph = 0; cur_v = 0; cur_d = 0; nxt_v = 0; nxt_d = 0;
            cur_t = "R9"; nxt_t = "R9";
        end else begin
            cur_v = nxt_v; cur_d = nxt_d;
            cur_t = nxt_v ? nxt_t : "R8";
            nxt_v = 0; nxt_d = 0;
            if (weight_load) begin
                for (int k = 0; k < 4; k++) mw[k] = $signed(weight_data[k*8 +: 8]);
            end else if (in_valid) begin
                if (!mph) begin
                    mx0 = $signed(in_data);
                    mph = 1;
                end else begin
                    int x1;
                    x1 = $signed(in_data);
                    cur_v = 1; cur_d = mw[0]*mx0 + mw[1]*x1; cur_t = {tag, " R5"};
                    nxt_v = 1; nxt_d = mw[2]*mx0 + mw[3]*x1; nxt_t = {tag, " R6"};
                    mph = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (primed && !done) begin
            checks++;
            if (out_valid !== cur_v || $signed(out_data) != cur_d) begin
                fails++;
                $display("FAIL %s: out_valid=%0d out_data=%0d expected valid=%0d data=%0d",
                         cur_t, out_valid, $signed(out_data), cur_v, cur_d);
            end
        end
    end

    task automatic drive(input bit r, input bit ld, input logic [31:0] wd,
                         input bit v, input logic [7:0] d);
        @(negedge clk);
        rst = r; weight_load = ld; weight_data = wd; in_valid = v; in_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 32'h0, 0, 8'h0);
    endtask

    task automatic vec(input logic [7:0] a, input logic [7:0] b);
        drive(0, 0, 32'h0, 1, a);
        drive(0, 0, 32'h0, 1, b);
    endtask

    task automatic load(input logic [31:0] wd, input bit with_valid);
        drive(0, 1, wd, with_valid, 8'd99);
    endtask

    initial begin
        rst = 1; weight_load = 0; weight_data = 0; in_valid = 0; in_data = 0;
        // reset state R9
        tag = "R9";
        idle(0);
        repeat (2) @(negedge clk);
        idle(2);
        // R9 R10: weights are zero after reset
        vec(8'd7, 8'd9);
        idle(3);
        // R1: field positions; R2: valid on load cycle ignored
        tag = "R1 R2";
        load(32'h04030201, 1);
        vec(8'd5, 8'd6);          // r0=17, r1=39
        idle(3);
        // R4: extremes
        tag = "R4";
        load(32'h80808080, 0);
        vec(8'h80, 8'h80);        // 32768 in both rows
        idle(1);
        load(32'h7F80807F, 0);
        vec(8'h7F, 8'h80);
        vec(8'h80, 8'h7F);
        vec(8'hFF, 8'h01);
        idle(3);
        // R7: back-to-back, overlapping, several weight sets
        tag = "R7";
        for (int g = 0; g < 6; g++) begin
            load($urandom, g[0]);
            for (int i = 0; i < 25; i++) vec(8'($urandom), 8'($urandom));
            idle(3);
        end
        // R3 R10: gaps between vectors, weights persist
        tag = "R3 R10";
        for (int i = 0; i < 30; i++) begin
            vec(8'($urandom), 8'($urandom));
            idle(i % 3);
        end
        idle(3);
        // R9: reset after x0 drops the half vector
        tag = "R9";
        load(32'h11223344, 0);
        drive(0, 0, 0, 1, 8'd3);
        drive(1, 0, 0, 1, 8'd4);
        idle(2);
        vec(8'd1, 8'd2);
        idle(3);
        // R9: reset while r0 is driven cancels r1
        load(32'h05060708, 0);
        vec(8'd10, 8'd20);
        drive(1, 0, 0, 0, 8'd0);
        idle(4);
        vec(8'd3, 8'd3);
        idle(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule